// File: doc/BRIEF.md
# Memory Word Trap Bit Controller

This block sits next to a memory bank in which every 128-bit word carries three trap bits. One bit belongs to the operating system and two belong to user code. For every memory request the block takes:

- the word's current trap bits, as read from the array;
- an 8-bit access prefix;
- a privileged flag and an optional direct write of the system bit.

From these it decides whether the access must trap. When it must, it names the cause. When it need not, it produces the trap bits to write back and says whether a write-back is needed at all.

The prefix holds, for each user bit, a test and an update. The test can ignore the bit, trap when the bit is set, or trap when it is clear. The update can keep, set, clear or toggle the bit. All tests look at the bits as they were before the access. A trap cancels every update.

The outcome is registered and appears exactly one cycle after the request. A two-state machine sequences it:
- ST_IDLE: no response is presented.
- ST_RESP: the captured outcome is presented for one cycle.

Every cycle with `req_valid` high moves the machine to ST_RESP. Every cycle without it moves the machine to ST_IDLE. ST_RESP therefore follows itself under back-to-back requests.

Top module: `trapctl`

## Requirements
- R1: After reset, out_valid, out_trap and out_wb_en are 0 and out_cause is 0.
- R2: The outcome of a request sampled on a clock edge is presented on the outputs from that edge until the next. out_valid is 1 exactly in the cycle after a cycle with req_valid, including back-to-back requests.
- R3: The trap bit vector is [0]=U, [1]=V, [2]=T. When T is 1 the access traps with cause 1. The single exception is a request with both req_priv and req_t_write high.
- R4: Test codes sit in prefix [1:0] for U and [5:4] for V. The codes are 00 ignore, 01 trap if the bit is 1, 10 trap if the bit is 0, and 11 ignore. A U trap reports cause 2 and a V trap reports cause 3.
- R5: When several conditions fire, the reported cause is chosen by priority: T first, then U, then V. out_trap is 1 exactly when out_cause is nonzero.
- R6: Update codes sit in prefix [3:2] for U and [7:6] for V. The codes are 00 keep, 01 set, 10 clear, 11 toggle. For a non-trapping access, out_bits carries the updated values.
- R7: Tests use the bits as they were before the access. On a trap, out_bits equals the input bits and out_wb_en is 0.
- R8: out_wb_en is 1 only for a non-trapping access whose out_bits differ from the input bits.
- R9: A request with req_priv and req_t_write high sets T to req_t_value when it does not trap. An unprivileged req_t_write leaves T unchanged.
- R10: out_addr carries the address of the request whose outcome is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Word address of the request |
| req_bits | input | NUM_USER+1 | Trap bits read from the array ([0]=U, [1]=V, top=T) |
| req_prefix | input | 4*NUM_USER | Access prefix: test and update code for each user bit |
| req_priv | input | 1 | Request comes from privileged code |
| req_t_write | input | 1 | Request asks to write T directly |
| req_t_value | input | 1 | Value for T on a privileged write |
| out_valid | output | 1 | Outcome presented this cycle |
| out_addr | output | ADDR_W | Address of the presented outcome |
| out_trap | output | 1 | Access traps |
| out_cause | output | $clog2(NUM_USER+2) | 0 none, 1 T, 2 U, 3 V |
| out_wb_en | output | 1 | Trap bits must be written back |
| out_bits | output | NUM_USER+1 | Trap bits after the access |

## Verification
The bench builds the block with its defaults: ADDR_W=32 and NUM_USER=2. With these values the prefix is eight bits and the trap-bit state is three bits. The whole input space of the decision therefore fits in a sweep of every bit state, every prefix and every combination of privilege and T write. That sweep covers both reserved test codes and every toggle case against a bench model.

Directed scenarios separately pin down:
- the reset outcome;
- the one-cycle latency under back-to-back requests;
- the priority among T, U and V;
- the protection of T from unprivileged writes.

// File: rtl/trapctl_pkg.sv
package trapctl_pkg;

    typedef enum logic [1:0] {
        TST_IGNORE = 2'b00,
        TST_SET    = 2'b01,
        TST_CLEAR  = 2'b10,
        TST_RSVD   = 2'b11
    } test_code_e;

    typedef enum logic [1:0] {
        UPD_KEEP  = 2'b00,
        UPD_SET   = 2'b01,
        UPD_CLEAR = 2'b10,
        UPD_FLIP  = 2'b11
    } upd_code_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } stage_e;

endpackage

// File: rtl/trapctl_test.sv
module trapctl_test
    import trapctl_pkg::*;
(
    input  logic [1:0] code,
    input  logic       cur,
    output logic       fire
);
    always_comb begin
        unique case (test_code_e'(code))
            TST_SET:   fire = cur;
            TST_CLEAR: fire = ~cur;
            TST_IGNORE,
            TST_RSVD:  fire = 1'b0;
            default:   fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/trapctl_update.sv
module trapctl_update
    import trapctl_pkg::*;
(
    input  logic [1:0] code,
    input  logic       cur,
    output logic       nxt
);
    always_comb begin
        unique case (upd_code_e'(code))
            UPD_KEEP:  nxt = cur;
            UPD_SET:   nxt = 1'b1;
            UPD_CLEAR: nxt = 1'b0;
            UPD_FLIP:  nxt = ~cur;
            default:   nxt = cur;
        endcase
    end
endmodule

// File: rtl/trapctl.sv
module trapctl
    import trapctl_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int NUM_USER = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic [ADDR_W-1:0]                 req_addr,
    input  logic [NUM_USER:0]                 req_bits,
    input  logic [4*NUM_USER-1:0]             req_prefix,
    input  logic                              req_priv,
    input  logic                              req_t_write,
    input  logic                              req_t_value,
    output logic                              out_valid,
    output logic [ADDR_W-1:0]                 out_addr,
    output logic                              out_trap,
    output logic [$clog2(NUM_USER+2)-1:0]     out_cause,
    output logic                              out_wb_en,
    output logic [NUM_USER:0]                 out_bits
);
    localparam int BITS_W  = NUM_USER + 1;
    localparam int T_IDX   = NUM_USER;
    localparam int CAUSE_W = $clog2(NUM_USER + 2);

    logic [NUM_USER-1:0] user_fire;
    logic [NUM_USER-1:0] user_next;

    for (genvar g = 0; g < NUM_USER; g++) begin : g_user
        trapctl_test u_test (
            .code (req_prefix[4*g+1 : 4*g]),
            .cur  (req_bits[g]),
            .fire (user_fire[g])
        );
        trapctl_update u_update (
            .code (req_prefix[4*g+3 : 4*g+2]),
            .cur  (req_bits[g]),
            .nxt  (user_next[g])
        );
    end

    logic               t_write_ok;
    logic               t_fire;
    logic [CAUSE_W-1:0] cause_d;
    logic               trap_d;
    logic [BITS_W-1:0]  bits_d;
    logic               wb_d;

    assign t_write_ok = req_priv & req_t_write;
    assign t_fire     = req_bits[T_IDX] & ~t_write_ok;

    // Priority: T, then user bit 0 (U), then user bit 1 (V), ...
    always_comb begin
        cause_d = '0;
        for (int i = NUM_USER - 1; i >= 0; i--) begin
            if (user_fire[i]) cause_d = CAUSE_W'(i + 2);
        end
        if (t_fire) cause_d = CAUSE_W'(1);
    end

    assign trap_d = (cause_d != '0);

    always_comb begin
        if (trap_d) begin
            bits_d = req_bits;
        end else begin
            bits_d = {(t_write_ok ? req_t_value : req_bits[T_IDX]), user_next};
        end
    end

    assign wb_d = ~trap_d & (bits_d != req_bits);

    // State register
    stage_e state;
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= req_valid ? ST_RESP : ST_IDLE;
    end

    // Captured outcome
    logic [ADDR_W-1:0]  cap_addr;
    logic               cap_trap;
    logic [CAUSE_W-1:0] cap_cause;
    logic               cap_wb;
    logic [BITS_W-1:0]  cap_bits;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr  <= '0;
            cap_trap  <= 1'b0;
            cap_cause <= '0;
            cap_wb    <= 1'b0;
            cap_bits  <= '0;
        end else if (req_valid) begin
            cap_addr  <= req_addr;
            cap_trap  <= trap_d;
            cap_cause <= cause_d;
            cap_wb    <= wb_d;
            cap_bits  <= bits_d;
        end
    end

    // Output process
    always_comb begin
        out_addr  = cap_addr;
        out_bits  = cap_bits;
        unique case (state)
            ST_IDLE: begin
                out_valid = 1'b0;
                out_trap  = 1'b0;
                out_cause = '0;
                out_wb_en = 1'b0;
            end
            ST_RESP: begin
                out_valid = 1'b1;
                out_trap  = cap_trap;
                out_cause = cap_cause;
                out_wb_en = cap_wb;
            end
            default: begin
                out_valid = 1'b0;
                out_trap  = 1'b0;
                out_cause = '0;
                out_wb_en = 1'b0;
            end
        endcase
    end

    // R2
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R2
    no_resp_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    // R3
    t_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_bits[T_IDX] && !(req_priv && req_t_write))
        |=> (out_trap && out_cause == CAUSE_W'(1)));

    // R7
    trap_keeps_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> (!out_wb_en && out_bits == $past(req_bits)));

    // R8
    wb_means_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_wb_en |-> (out_valid && !out_trap && out_bits != $past(req_bits)));

    // R9
    t_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(req_priv)) |-> out_bits[T_IDX] == $past(req_bits[T_IDX]));

    // R10
    addr_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_addr == $past(req_addr));

endmodule

// File: tb/test_trapctl.sv
`timescale 1ns/1ps
module test_trapctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_bits = '0;
    logic [7:0]  req_prefix = '0;
    logic        req_priv = 1'b0;
    logic        req_t_write = 1'b0;
    logic        req_t_value = 1'b0;
    logic        out_valid;
    logic [31:0] out_addr;
    logic        out_trap;
    logic [1:0]  out_cause;
    logic        out_wb_en;
    logic [2:0]  out_bits;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    trapctl i_trapctl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_bits(req_bits), .req_prefix(req_prefix), .req_priv(req_priv),
        .req_t_write(req_t_write), .req_t_value(req_t_value),
        .out_valid(out_valid), .out_addr(out_addr), .out_trap(out_trap),
        .out_cause(out_cause), .out_wb_en(out_wb_en), .out_bits(out_bits)
    );

    task automatic chk(input string r, input logic [63:0] got, input logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", r, got, exp);
        end
    endtask

    // Bench model: returns {wb, trap, cause[1:0], bits[2:0]}
    function automatic logic [6:0] model(input logic [2:0] b, input logic [7:0] p,
                                         input logic priv, input logic tw, input logic tv);
        logic tr_t, fu, fv, nu, nv, nt, wb;
        logic [1:0] cause;
        logic [2:0] nb;
        tr_t = b[2] && !(priv && tw);
        fu = (p[1:0] == 2'b01 && b[0]) || (p[1:0] == 2'b10 && !b[0]);
        fv = (p[5:4] == 2'b01 && b[1]) || (p[5:4] == 2'b10 && !b[1]);
        cause = tr_t ? 2'd1 : fu ? 2'd2 : fv ? 2'd3 : 2'd0;
        case (p[3:2]) 2'b00: nu = b[0]; 2'b01: nu = 1'b1; 2'b10: nu = 1'b0; default: nu = ~b[0]; endcase
        case (p[7:6]) 2'b00: nv = b[1]; 2'b01: nv = 1'b1; 2'b10: nv = 1'b0; default: nv = ~b[1]; endcase
        nt = (priv && tw) ? tv : b[2];
        nb = (cause != 0) ? b : {nt, nv, nu};
        wb = (cause == 0) && (nb != b);
        return {wb, (cause != 0), cause, nb};
    endfunction

    // One request; outputs are stable at the negedge following the capture edge
    task automatic do_req(input logic [31:0] a, input logic [2:0] b, input logic [7:0] p,
                          input logic priv, input logic tw, input logic tv);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_bits = b; req_prefix = p;
        req_priv = priv; req_t_write = tw; req_t_value = tv;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [6:0] got_vec();
        return {out_wb_en, out_trap, out_cause, out_bits};
    endfunction

    task automatic t_reset();
        chk("R1 valid after reset", out_valid, 0);
        chk("R1 trap after reset", out_trap, 0);
        chk("R1 cause after reset", out_cause, 0);
        chk("R1 wb after reset", out_wb_en, 0);
    endtask

    task automatic t_latency();
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h100; req_bits = 3'b000; req_prefix = 8'h04;
        req_priv = 0; req_t_write = 0;
        #1 chk("R2 not valid before edge", out_valid, 0);
        @(negedge clk);
        chk("R2 valid after first", out_valid, 1);
        chk("R10 addr first", out_addr, 32'h100);
        req_addr = 32'h200; req_bits = 3'b001; req_prefix = 8'h01;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 back-to-back valid", out_valid, 1);
        chk("R10 addr second", out_addr, 32'h200);
        chk("R4 U trap on set cause", out_cause, 2);
        @(negedge clk);
        chk("R2 valid drops", out_valid, 0);
    endtask

    task automatic t_tbit();
        do_req(32'h11, 3'b100, 8'h00, 0, 0, 0);
        chk("R3 T traps", out_trap, 1);
        chk("R3 T cause", out_cause, 1);
        do_req(32'h12, 3'b100, 8'h00, 1, 0, 0);
        chk("R3 privileged read still traps", out_cause, 1);
        do_req(32'h13, 3'b100, 8'h00, 1, 1, 0);
        chk("R3 privileged T write no trap", out_trap, 0);
        chk("R9 T cleared", out_bits, 3'b000);
        chk("R8 wb on T clear", out_wb_en, 1);
    endtask

    task automatic t_tests();
        do_req(32'h20, 3'b000, 8'h02, 0, 0, 0);
        chk("R4 U trap on clear", out_cause, 2);
        do_req(32'h21, 3'b001, 8'h03, 0, 0, 0);
        chk("R4 U reserved ignored", out_trap, 0);
        do_req(32'h22, 3'b010, 8'h10, 0, 0, 0);
        chk("R4 V trap on set", out_cause, 3);
        do_req(32'h23, 3'b010, 8'h20, 0, 0, 0);
        chk("R4 V clear test no trap", out_trap, 0);
    endtask

    task automatic t_priority();
        do_req(32'h30, 3'b111, 8'h11, 0, 0, 0);
        chk("R5 T beats U and V", out_cause, 1);
        do_req(32'h31, 3'b011, 8'h11, 0, 0, 0);
        chk("R5 U beats V", out_cause, 2);
        chk("R5 trap flag", out_trap, 1);
    endtask

    task automatic t_update();
        do_req(32'h40, 3'b000, 8'h44, 0, 0, 0);
        chk("R6 set both", out_bits, 3'b011);
        do_req(32'h41, 3'b011, 8'hCC, 0, 0, 0);
        chk("R6 toggle both", out_bits, 3'b000);
        do_req(32'h42, 3'b011, 8'h88, 0, 0, 0);
        chk("R6 clear both", out_bits, 3'b000);
        do_req(32'h43, 3'b010, 8'h00, 0, 0, 0);
        chk("R8 no change no wb", out_wb_en, 0);
        chk("R6 keep", out_bits, 3'b010);
    endtask

    task automatic t_no_update_on_trap();
        // U test trap-on-clear on U=0 with a set update on V: nothing written
        do_req(32'h50, 3'b000, 8'h42, 0, 0, 0);
        chk("R7 trap keeps bits", out_bits, 3'b000);
        chk("R7 trap no wb", out_wb_en, 0);
        // Toggle U while testing pre-access U=1 for set: traps on old value
        do_req(32'h51, 3'b001, 8'h0D, 0, 0, 0);
        chk("R7 test uses old value", out_cause, 2);
    endtask

    task automatic t_priv_t();
        do_req(32'h60, 3'b000, 8'h00, 0, 1, 1);
        chk("R9 unprivileged T write ignored", out_bits, 3'b000);
        chk("R9 unprivileged no wb", out_wb_en, 0);
        do_req(32'h61, 3'b000, 8'h00, 1, 1, 1);
        chk("R9 privileged T set", out_bits, 3'b100);
    endtask

    task automatic t_sweep();
        for (int b = 0; b < 8; b++) begin
            for (int p = 0; p < 256; p++) begin
                for (int m = 0; m < 8; m++) begin
                    do_req(32'(b * 4096 + p * 8 + m), 3'(b), 8'(p), m[0], m[1], m[2]);
                    chk("R6 sweep outcome", got_vec(), model(3'(b), 8'(p), m[0], m[1], m[2]));
                end
            end
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latency();
        t_tbit();
        t_tests();
        t_priority();
        t_update();
        t_no_update_on_trap();
        t_priv_t();
        t_sweep();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule